// File: doc/BRIEF.md
# Inter-Processor Doorbell Interrupt Pair

Two small register-mapped ports, one facing each of two processors, let one processor ring a doorbell on the other. A typical use is to announce that a shared buffer has been filled. Each port has a one-bit bell output that only its own processor writes. The bell output of each side is wired inside the block to the bell input of the other side.

On the receiving side, the incoming bell passes through a synchronizer and then an edge detector. By default the detector fires on a falling transition. A detected edge sets a sticky capture bit, and that bit stays set until the local processor writes the capture register. The interrupt request is high while both the capture bit and the mask bit are 1. Because the capture bit is sticky, a single short pulse from the sender is enough: the sender does not have to hold a level.

Software brings a port up in three writes: mask to 0, a write to the capture register, then mask to 1.

Top module: `doorbell_pair`

## Requirements
- R1: After reset, on both sides the bell output, the mask bit and the capture bit are 0, and the interrupt request is low.
- R2: A write to offset 0 loads bit 0 of the write data into the local bell output. A read of offset 0 returns the bell output in bit 0 and the synchronized bell input in bit 1, with all other bits 0.
- R3: Side A's bell output drives side B's bell input, and side B's bell output drives side A's bell input. A level written on one side appears in bit 1 of the other side's offset 0 in the third cycle after the write.
- R4: A falling transition on the synchronized bell input sets the capture bit, which is read as bit 0 of offset 3. It becomes visible in the fourth cycle after the sender's write. A rising transition does not set the capture bit.
- R5: The capture bit is sticky. It holds after the bell input returns to any level, until the capture register is written.
- R6: Offset 2 bit 0 holds the mask. The interrupt request equals capture AND mask.
- R7: Any write to offset 3 clears the capture bit, whatever the write data, and the interrupt request drops in the next cycle.
- R8: If an edge is detected in the same cycle as a write to offset 3, the capture bit ends up set.
- R9: Offset 1 reads as 0, and writes to it change nothing.
- R10: Read data is 0 whenever the read strobe is low.
- R11: A register write on one side changes none of the other side's mask, capture or interrupt state, except through the bell wire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| a_addr_i | input | 2 | Side A register offset |
| a_rd_i | input | 1 | Side A read strobe |
| a_wr_i | input | 1 | Side A write strobe |
| a_wdata_i | input | DATA_W | Side A write data |
| a_rdata_o | output | DATA_W | Side A read data (combinational) |
| a_irq_o | output | 1 | Side A interrupt request |
| b_addr_i | input | 2 | Side B register offset |
| b_rd_i | input | 1 | Side B read strobe |
| b_wr_i | input | 1 | Side B write strobe |
| b_wdata_i | input | DATA_W | Side B write data |
| b_rdata_o | output | DATA_W | Side B read data (combinational) |
| b_irq_o | output | 1 | Side B interrupt request |

## Verification
Read data is combinational, so it is due in the same cycle as the read strobe. Register writes take effect at the next edge.

A bell write reaches the peer's pin bit after two more edges, and the peer's capture bit and interrupt after three more. A capture clear drops the interrupt one edge after the write.

The bench steps a cycle model of both sides once per rising edge. It drives strobes and compares every output at the falling edge, so each check sees the state produced by exactly the edges counted above. Directed sequences place a clear write on the exact cycle in which an edge is detected, and check the bell pin one cycle before and at its due cycle.

// File: rtl/doorbell_pkg.sv
package doorbell_pkg;
  localparam int unsigned REG_AW = 2;

  localparam logic [REG_AW-1:0] OFS_PINS = 2'd0;
  localparam logic [REG_AW-1:0] OFS_MASK = 2'd2;
  localparam logic [REG_AW-1:0] OFS_CAP  = 2'd3;

  typedef enum logic [1:0] {
    EDGE_FALL = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_BOTH = 2'd2
  } edge_sel_e;
endpackage

// File: rtl/doorbell_sync.sv
module doorbell_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stage_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q <= '0;
        else         stage_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q <= '0;
        else         stage_q <= {stage_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/doorbell_edge.sv
module doorbell_edge
  import doorbell_pkg::*;
#(
  parameter edge_sel_e EDGE = EDGE_FALL
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic hit_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  generate
    if (EDGE == EDGE_FALL) begin : g_fall
      assign hit_o = prev_q & ~lvl_i;
    end else if (EDGE == EDGE_RISE) begin : g_rise
      assign hit_o = ~prev_q & lvl_i;
    end else begin : g_both
      assign hit_o = prev_q ^ lvl_i;
    end
  endgenerate
endmodule

// File: rtl/doorbell_port.sv
module doorbell_port
  import doorbell_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SYNC_STAGES = 2,
  parameter edge_sel_e   EDGE        = EDGE_FALL
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              bell_o,
  input  logic              bell_i
);
  logic bell_sync;
  logic hit;
  logic out_q, mask_q, cap_q;
  logic wr_pins, wr_mask, wr_cap;
  logic unused_wdata;

  assign unused_wdata = ^wdata_i[DATA_W-1:1];

  doorbell_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (bell_i),
    .q_o   (bell_sync)
  );

  doorbell_edge #(.EDGE(EDGE)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (bell_sync),
    .hit_o (hit)
  );

  assign wr_pins = wr_i && (addr_i == OFS_PINS);
  assign wr_mask = wr_i && (addr_i == OFS_MASK);
  assign wr_cap  = wr_i && (addr_i == OFS_CAP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q  <= 1'b0;
      mask_q <= 1'b0;
      cap_q  <= 1'b0;
    end else begin
      if (wr_pins) out_q  <= wdata_i[0];
      if (wr_mask) mask_q <= wdata_i[0];
      // a new edge outranks a clear in the same cycle
      cap_q <= (cap_q & ~wr_cap) | hit;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      unique case (addr_i)
        OFS_PINS: rdata_o[1:0] = {bell_sync, out_q};
        OFS_MASK: rdata_o[0]   = mask_q;
        OFS_CAP:  rdata_o[0]   = cap_q;
        default:  rdata_o      = '0;
      endcase
    end
  end

  assign irq_o  = cap_q & mask_q;
  assign bell_o = out_q;

  assert_cap_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> cap_q);
  assert_cap_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_cap && !hit) |=> !cap_q);
  assert_cap_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_q && !wr_cap) |=> cap_q);
  assert_out_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_pins |=> $stable(bell_o));
  assert_irq_cause_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($past(hit) || $past(wr_mask)));
endmodule

// File: rtl/doorbell_pair.sv
module doorbell_pair
  import doorbell_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SYNC_STAGES = 2,
  parameter edge_sel_e   EDGE        = EDGE_FALL
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        a_addr_i,
  input  logic              a_rd_i,
  input  logic              a_wr_i,
  input  logic [DATA_W-1:0] a_wdata_i,
  output logic [DATA_W-1:0] a_rdata_o,
  output logic              a_irq_o,
  input  logic [1:0]        b_addr_i,
  input  logic              b_rd_i,
  input  logic              b_wr_i,
  input  logic [DATA_W-1:0] b_wdata_i,
  output logic [DATA_W-1:0] b_rdata_o,
  output logic              b_irq_o
);
  logic bell_a2b, bell_b2a;

  doorbell_port #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES), .EDGE(EDGE)) u_port_a (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .addr_i (a_addr_i),
    .rd_i   (a_rd_i),
    .wr_i   (a_wr_i),
    .wdata_i(a_wdata_i),
    .rdata_o(a_rdata_o),
    .irq_o  (a_irq_o),
    .bell_o (bell_a2b),
    .bell_i (bell_b2a)
  );

  doorbell_port #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES), .EDGE(EDGE)) u_port_b (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .addr_i (b_addr_i),
    .rd_i   (b_rd_i),
    .wr_i   (b_wr_i),
    .wdata_i(b_wdata_i),
    .rdata_o(b_rdata_o),
    .irq_o  (b_irq_o),
    .bell_o (bell_b2a),
    .bell_i (bell_a2b)
  );
endmodule

// File: tb/doorbell_pair_test.sv
`timescale 1ns/1ps
module doorbell_pair_test;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [1:0]    d_addr  [2];
  logic          d_rd    [2];
  logic          d_wr    [2];
  logic [DW-1:0] d_wdata [2];
  logic [1:0]    s_addr  [2];
  logic          s_rd    [2];
  logic          s_wr    [2];
  logic [DW-1:0] s_wdata [2];
  logic [DW-1:0] rdata_a, rdata_b;
  logic          irq_a, irq_b;

  doorbell_pair uut (
    .clk_i(clk), .rst_ni(rst_n),
    .a_addr_i(d_addr[0]), .a_rd_i(d_rd[0]), .a_wr_i(d_wr[0]), .a_wdata_i(d_wdata[0]),
    .a_rdata_o(rdata_a), .a_irq_o(irq_a),
    .b_addr_i(d_addr[1]), .b_rd_i(d_rd[1]), .b_wr_i(d_wr[1]), .b_wdata_i(d_wdata[1]),
    .b_rdata_o(rdata_b), .b_irq_o(irq_b)
  );

  // cycle model
  logic m_out[2], m_mask[2], m_cap[2], m_s1[2], m_s2[2], m_p[2];

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] exp_rdata(input int s);
    logic [DW-1:0] r = '0;
    if (d_rd[s]) begin
      case (d_addr[s])
        2'd0: r[1:0] = {m_s2[s], m_out[s]};
        2'd2: r[0] = m_mask[s];
        2'd3: r[0] = m_cap[s];
        default: r = '0;
      endcase
    end
    return r;
  endfunction

  function automatic string tag_of(input int s);
    if (!d_rd[s]) return "R10";
    case (d_addr[s])
      2'd0: return "R2";
      2'd1: return "R9";
      2'd2: return "R6";
      default: return "R4";
    endcase
  endfunction

  task automatic op(input int s, input logic [1:0] a, input logic r, input logic w, input logic [DW-1:0] d);
    s_addr[s] = a; s_rd[s] = r; s_wr[s] = w; s_wdata[s] = d;
  endtask

  // one clock: apply staged ops, check mid-cycle, advance model on the edge
  task automatic step(input string tag = "", input int side = 0,
                      input logic [DW-1:0] exp = '0, input bit on_irq = 1'b0);
    logic n_out[2], n_mask[2], n_cap[2], fall;
    @(negedge clk);
    for (int s = 0; s < 2; s++) begin
      d_addr[s] = s_addr[s]; d_rd[s] = s_rd[s]; d_wr[s] = s_wr[s]; d_wdata[s] = s_wdata[s];
      s_addr[s] = '0; s_rd[s] = 1'b0; s_wr[s] = 1'b0; s_wdata[s] = '0;
    end
    #1;
    chk("R6 irq A", {31'b0, irq_a}, {31'b0, m_cap[0] & m_mask[0]});
    chk("R6 irq B", {31'b0, irq_b}, {31'b0, m_cap[1] & m_mask[1]});
    chk({tag_of(0), " rdata A"}, rdata_a, exp_rdata(0));
    chk({tag_of(1), " rdata B"}, rdata_b, exp_rdata(1));
    if (tag != "") begin
      if (on_irq) chk(tag, {31'b0, (side == 0) ? irq_a : irq_b}, exp);
      else        chk(tag, (side == 0) ? rdata_a : rdata_b, exp);
    end
    @(posedge clk);
    if (!rst_n) begin
      for (int s = 0; s < 2; s++) begin
        m_out[s] = 0; m_mask[s] = 0; m_cap[s] = 0; m_s1[s] = 0; m_s2[s] = 0; m_p[s] = 0;
      end
    end else begin
      for (int s = 0; s < 2; s++) begin
        fall = m_p[s] & ~m_s2[s];
        n_out[s]  = (d_wr[s] && d_addr[s] == 2'd0) ? d_wdata[s][0] : m_out[s];
        n_mask[s] = (d_wr[s] && d_addr[s] == 2'd2) ? d_wdata[s][0] : m_mask[s];
        n_cap[s]  = (m_cap[s] & ~(d_wr[s] && d_addr[s] == 2'd3)) | fall;
      end
      for (int s = 0; s < 2; s++) begin
        m_p[s]  = m_s2[s];
        m_s2[s] = m_s1[s];
        m_s1[s] = m_out[1-s];
      end
      for (int s = 0; s < 2; s++) begin
        m_out[s] = n_out[s]; m_mask[s] = n_mask[s]; m_cap[s] = n_cap[s];
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4242);
    for (int s = 0; s < 2; s++) begin
      op(s, 2'd0, 1'b0, 1'b0, '0);
      d_addr[s] = '0; d_rd[s] = 0; d_wr[s] = 0; d_wdata[s] = '0;
      m_out[s] = 0; m_mask[s] = 0; m_cap[s] = 0; m_s1[s] = 0; m_s2[s] = 0; m_p[s] = 0;
    end

    // R1: reset state
    step("R1 irq A in reset", 0, '0, 1'b1);
    step();
    @(negedge clk); rst_n = 1'b1;
    op(0, 2'd2, 1, 0, '0); op(1, 2'd3, 1, 0, '0); step("R1 mask A", 0, '0);
    op(0, 2'd3, 1, 0, '0); op(1, 2'd0, 1, 0, '0); step("R1 pins B", 1, '0);
    step("R1 irq B", 1, '0, 1'b1);

    // R6: bring-up order on both sides
    op(0, 2'd2, 0, 1, '0); op(1, 2'd2, 0, 1, '0); step();
    op(0, 2'd3, 0, 1, '0); op(1, 2'd3, 0, 1, '0); step();
    op(0, 2'd2, 0, 1, 32'h1); op(1, 2'd2, 0, 1, 32'h1); step();
    op(0, 2'd2, 1, 0, '0); step("R6 mask readback", 0, 32'h1);

    // R3: A raises bell; visible at B in the third cycle after the write
    op(0, 2'd0, 1, 1, 32'h1); step();
    op(1, 2'd0, 1, 0, '0); step("R3 pin B early", 1, 32'h0);
    op(1, 2'd0, 1, 0, '0); step("R3 pin B early2", 1, 32'h0);
    op(1, 2'd0, 1, 0, '0); step("R3 pin B due", 1, 32'h2);
    // R4: rising edge did not capture
    op(1, 2'd3, 1, 0, '0); step("R4 no capture on rise", 1, 32'h0);

    // R5: A drops bell (falling edge); capture sticks, irq on B only
    op(0, 2'd0, 0, 1, 32'hFFFF_FFFE); step();
    idle(2);
    op(1, 2'd3, 1, 0, '0); step("R4 not yet", 1, 32'h0);
    op(1, 2'd3, 1, 0, '0); step("R4 capture set", 1, 32'h1);
    idle(5);
    step("R5 irq B sticky", 1, 32'h1, 1'b1);
    step("R11 irq A quiet", 0, 32'h0, 1'b1);

    // R7: any-data write clears, irq drops next cycle
    op(1, 2'd3, 0, 1, 32'h0); step("R7 irq before clear", 1, 32'h1, 1'b1);
    op(1, 2'd3, 1, 0, '0); step("R7 capture cleared", 1, 32'h0);
    step("R7 irq dropped", 1, 32'h0, 1'b1);

    // R8: clear collides with a detected edge
    op(0, 2'd0, 0, 1, 32'h1); step(); idle(3);
    op(0, 2'd0, 0, 1, 32'h0); step(); idle(2);
    op(1, 2'd3, 0, 1, 32'hDEAD_BEEF); step();
    op(1, 2'd3, 1, 0, '0); step("R8 edge beats clear", 1, 32'h1);
    op(1, 2'd3, 0, 1, '0); step();

    // R9: offset 1 writes ignored, reads zero
    op(0, 2'd1, 0, 1, 32'hFFFF_FFFF); step();
    op(0, 2'd1, 1, 0, '0); step("R9 reads zero", 0, 32'h0);
    op(0, 2'd2, 1, 0, '0); step("R9 mask untouched", 0, 32'h1);
    op(0, 2'd0, 1, 0, '0); step("R9 pins untouched", 0, 32'h0);

    // R11: B's mask write leaves A's mask
    op(1, 2'd2, 0, 1, 32'h0); step();
    op(0, 2'd2, 1, 0, '0); step("R11 A mask kept", 0, 32'h1);

    // R10: no strobe, no data
    op(0, 2'd2, 0, 0, '0); step("R10 idle read", 0, 32'h0);

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      for (int s = 0; s < 2; s++)
        op(s, 2'($urandom % 4), 1'($urandom % 2), ($urandom % 3) == 0, $urandom);
      step();
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule